// File: doc/BRIEF.md
# Lowest-Set-Bit Mask Execution Unit

This block is a one-stage execution slice for a single bit-manipulation operation. From a source operand it builds a mask of ones that starts at bit 0 and stops at the lowest set bit of the source, including that bit. It also produces the status flags that go with the operation. The mask equals `(src - 1) XOR src`, taken at the active operand size.

The operand size depends on the processor execution mode and on the width bit of the vector prefix. The unit raises an invalid-opcode fault when the vector-length bit is set, or when the processor is in a mode where the operation may not run. Results, flags and the fault bit are all registered and appear one clock after the input strobe.

Fetch, prefix decoding, memory operand access and writeback happen outside this unit. The unit receives operands that have already been decoded.

Top module: `lsbm_unit`

## Requirements
- R1: One clock after an accepted input with no fault, `out_result` equals `(src - 1) XOR src`, computed at the active operand size, and `out_valid` is 1.
- R2: If the source is zero at the active operand size, every result bit of that size is 1 and `out_cf` is 1. For any nonzero source, `out_cf` is 0.
- R3: `out_sf` equals the top bit of the result at the active operand size: bit 31 for 32-bit operation and bit 63 for 64-bit operation.
- R4: `out_zf`, `out_of`, `out_af` and `out_pf` are always 0.
- R5: Outside 64-bit mode the operand size is 32 bits, whatever the value of `in_w`. The `in_mode` encoding is 2'b00 real, 2'b01 virtual-8086, 2'b10 protected/compatibility and 2'b11 64-bit.
- R6: In 64-bit mode (`in_mode` = 2'b11), `in_w` = 1 selects 64-bit operation and `in_w` = 0 selects 32-bit operation.
- R7: For 32-bit operation, bits 63:32 of `out_result` are 0, and only bits 31:0 of the source are used.
- R8: An accepted input with `in_vl` = 1 yields `out_valid` = 1 and `out_fault` = 1 one clock later, with the result and all flags at 0.
- R9: An accepted input in real mode (2'b00) or virtual-8086 mode (2'b01) yields `out_fault` = 1 one clock later, with the result and all flags at 0.
- R10: A cycle with `in_valid` = 0 yields all outputs at 0 one clock later. Outputs never change except at a clock edge.
- R11: A synchronous active-high `rst` clears every output register at the next clock edge. This includes `out_valid` and `out_fault`, even when an input is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; operands are accepted when high |
| in_src | input | 64 | Source operand |
| in_mode | input | 2 | Execution mode: 00 real, 01 virtual-8086, 10 protected/compatibility, 11 64-bit |
| in_vl | input | 1 | Vector-length bit; must be 0 |
| in_w | input | 1 | Width bit; selects 64-bit operation in 64-bit mode |
| out_valid | output | 1 | Registered valid |
| out_result | output | 64 | Mask result, zero-extended for 32-bit operation |
| out_cf | output | 1 | Carry flag: source was zero |
| out_sf | output | 1 | Sign flag: top bit of the result at the active size |
| out_zf | output | 1 | Zero flag, always 0 |
| out_of | output | 1 | Overflow flag, always 0 |
| out_af | output | 1 | Adjust flag, driven to 0 |
| out_pf | output | 1 | Parity flag, driven to 0 |
| out_fault | output | 1 | Invalid-opcode fault; result not to be written back |

## Verification
The assertions assume that `in_mode`, `in_vl` and `in_w` are only meaningful in a cycle where `in_valid` is high. They also assume that reset is held for at least one edge before the first checked cycle, so that every `|=>` check has a defined predecessor. The stimulus changes inputs only on the falling clock edge. It cycles through all four mode codes, both values of the width bit, and both values of the length bit. It covers a zero source at each size, and sources whose lowest set bit is bit 0, bit 31 or bit 63. It includes narrow sources with junk in the upper half, and idle gaps and a reset in the middle of a run with valid input present.

// File: rtl/lsbm_pkg.sv
package lsbm_pkg;

    typedef enum logic [1:0] {
        EXEC_REAL = 2'b00,
        EXEC_V86  = 2'b01,
        EXEC_PROT = 2'b10,
        EXEC_LONG = 2'b11
    } exec_mode_e;

    typedef enum logic {
        SIZE_NARROW = 1'b0,
        SIZE_WIDE   = 1'b1
    } opsize_e;

    typedef struct packed {
        logic cf;
        logic sf;
        logic zf;
        logic of;
        logic af;
        logic pf;
    } flag_t;

    localparam flag_t FLAGS_CLEAR = '{cf: 1'b0, sf: 1'b0, zf: 1'b0, of: 1'b0, af: 1'b0, pf: 1'b0};

    function automatic logic mode_allows(exec_mode_e m);
        return (m == EXEC_PROT) || (m == EXEC_LONG);
    endfunction

endpackage

// File: rtl/lsbm_decode.sv
module lsbm_decode
    import lsbm_pkg::*;
(
    input  exec_mode_e mode,
    input  logic       vl,
    input  logic       w,
    output opsize_e    size,
    output logic       fault
);
    always_comb begin
        size  = (mode == EXEC_LONG && w) ? SIZE_WIDE : SIZE_NARROW;
        fault = vl || !mode_allows(mode);
    end
endmodule

// File: rtl/lsbm_mask.sv
module lsbm_mask
    import lsbm_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] src,
    input  opsize_e           size,
    output logic [DATA_W-1:0] result,
    output flag_t             flags
);
    localparam int unsigned NARROW_W = DATA_W / 2;
    localparam logic [DATA_W-1:0]   WIDE_ONE   = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [NARROW_W-1:0] NARROW_ONE = {{(NARROW_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0]   wide_mask;
    logic [NARROW_W-1:0] narrow_src;
    logic [NARROW_W-1:0] narrow_mask;

    assign narrow_src  = src[NARROW_W-1:0];
    assign wide_mask   = (src - WIDE_ONE) ^ src;
    assign narrow_mask = (narrow_src - NARROW_ONE) ^ narrow_src;

    always_comb begin
        flags = FLAGS_CLEAR;
        if (size == SIZE_WIDE) begin
            result   = wide_mask;
            flags.cf = (src == '0);
            flags.sf = wide_mask[DATA_W-1];
        end else begin
            result   = {{(DATA_W-NARROW_W){1'b0}}, narrow_mask};
            flags.cf = (narrow_src == '0);
            flags.sf = narrow_mask[NARROW_W-1];
        end
    end
endmodule

// File: rtl/lsbm_stage.sv
module lsbm_stage
    import lsbm_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              fault,
    input  logic [DATA_W-1:0] result,
    input  flag_t             flags,
    output logic              valid_q,
    output logic              fault_q,
    output logic [DATA_W-1:0] result_q,
    output flag_t             flags_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            fault_q  <= 1'b0;
            result_q <= '0;
            flags_q  <= FLAGS_CLEAR;
        end else begin
            valid_q <= take;
            fault_q <= take && fault;
            if (take && !fault) begin
                result_q <= result;
                flags_q  <= flags;
            end else begin
                result_q <= '0;
                flags_q  <= FLAGS_CLEAR;
            end
        end
    end

    assert_fault_squash_R8: assert property (@(posedge clk) disable iff (rst)
        fault_q |-> (result_q == '0 && flags_q == FLAGS_CLEAR && valid_q));

    assert_fixed_flags_R4: assert property (@(posedge clk) disable iff (rst)
        !(flags_q.zf || flags_q.of || flags_q.af || flags_q.pf));
endmodule

// File: rtl/lsbm_unit.sv
module lsbm_unit
    import lsbm_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_src,
    input  logic [1:0]        in_mode,
    input  logic              in_vl,
    input  logic              in_w,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_cf,
    output logic              out_sf,
    output logic              out_zf,
    output logic              out_of,
    output logic              out_af,
    output logic              out_pf,
    output logic              out_fault
);
    localparam int unsigned NARROW_W = DATA_W / 2;

    opsize_e           size;
    logic              fault;
    logic [DATA_W-1:0] mask;
    flag_t             flags;
    flag_t             flags_q;

    lsbm_decode u_decode (
        .mode  (exec_mode_e'(in_mode)),
        .vl    (in_vl),
        .w     (in_w),
        .size  (size),
        .fault (fault)
    );

    lsbm_mask #(.DATA_W(DATA_W)) u_mask (
        .src    (in_src),
        .size   (size),
        .result (mask),
        .flags  (flags)
    );

    lsbm_stage #(.DATA_W(DATA_W)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .take     (in_valid),
        .fault    (fault),
        .result   (mask),
        .flags    (flags),
        .valid_q  (out_valid),
        .fault_q  (out_fault),
        .result_q (out_result),
        .flags_q  (flags_q)
    );

    assign out_cf = flags_q.cf;
    assign out_sf = flags_q.sf;
    assign out_zf = flags_q.zf;
    assign out_of = flags_q.of;
    assign out_af = flags_q.af;
    assign out_pf = flags_q.pf;

    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_fault && out_result == '0));

    assert_zero_carry_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_vl && in_mode == 2'b11 && in_w && in_src == '0)
            |=> (out_cf && out_result == '1));

    assert_mode_fault_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_mode[1]) |=> (out_valid && out_fault));

    assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(in_mode == 2'b11 && in_w)) |=> (out_result[DATA_W-1:NARROW_W] == '0));

    assert_valid_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
endmodule

// File: tb/lsbm_unit_tb_top.sv
`timescale 1ns/1ps
module lsbm_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_src = '0;
    logic [1:0]  in_mode = 2'b00;
    logic        in_vl = 1'b0;
    logic        in_w = 1'b0;
    logic        out_valid, out_cf, out_sf, out_zf, out_of, out_af, out_pf, out_fault;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        bit          valid;
        bit          fault;
        logic [63:0] res;
        bit          cf;
        bit          sf;
    } expect_t;

    expect_t pending[$];

    always #4 clk = ~clk;

    lsbm_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
        .in_mode(in_mode), .in_vl(in_vl), .in_w(in_w),
        .out_valid(out_valid), .out_result(out_result),
        .out_cf(out_cf), .out_sf(out_sf), .out_zf(out_zf), .out_of(out_of),
        .out_af(out_af), .out_pf(out_pf), .out_fault(out_fault)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic expect_t model(bit r, bit v, logic [63:0] s, logic [1:0] m, bit vl, bit w);
        expect_t e;
        int n;
        bit hit;
        e = '{valid: 0, fault: 0, res: '0, cf: 0, sf: 0};
        if (r || !v) return e;
        e.valid = 1;
        if (vl || m == 2'b00 || m == 2'b01) begin
            e.fault = 1;
            return e;
        end
        n = (m == 2'b11 && w) ? 64 : 32;
        hit = 0;
        for (int i = 0; i < n; i++) begin
            if (!hit) begin
                e.res[i] = 1'b1;
                if (s[i]) hit = 1;
            end
        end
        e.cf = !hit;
        e.sf = e.res[n-1];
        return e;
    endfunction

    task automatic compare();
        expect_t e;
        e = pending.pop_front();
        chk("R1/R10/R11 valid", {63'b0, out_valid}, {63'b0, e.valid});
        chk("R8/R9/R11 fault", {63'b0, out_fault}, {63'b0, e.fault});
        chk("R1/R2/R7 result", out_result, e.res);
        chk("R2 cf", {63'b0, out_cf}, {63'b0, e.cf});
        chk("R3 sf", {63'b0, out_sf}, {63'b0, e.sf});
        chk("R4 zf/of/af/pf", {60'b0, out_zf, out_of, out_af, out_pf}, 64'b0);
    endtask

    task automatic step(bit r, bit v, logic [63:0] s, logic [1:0] m, bit vl, bit w);
        @(negedge clk);
        compare();
        rst = r; in_valid = v; in_src = s; in_mode = m; in_vl = vl; in_w = w;
        pending.push_back(model(r, v, s, m, vl, w));
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        pending.push_back(model(1, 0, '0, 2'b00, 0, 0));
        // R11: reset state observed at the first falling edge
        step(1, 0, '0, 2'b00, 0, 0);
        step(0, 0, '0, 2'b00, 0, 0);
        // R2/R6: zero source, 64-bit
        step(0, 1, 64'h0, 2'b11, 0, 1);
        // R2/R7: zero low half with junk above, 32-bit
        step(0, 1, 64'hDEAD_BEEF_0000_0000, 2'b11, 0, 0);
        // R3: lowest set bit 63 wide, bit 31 narrow
        step(0, 1, 64'h8000_0000_0000_0000, 2'b11, 0, 1);
        step(0, 1, 64'hFFFF_0000_8000_0000, 2'b11, 0, 0);
        // R1: bit 0 set
        step(0, 1, 64'h0000_0000_0000_0001, 2'b11, 0, 1);
        step(0, 1, 64'h0123_4567_89AB_CDE0, 2'b11, 0, 1);
        // R5: width bit ignored in protected/compatibility mode
        step(0, 1, 64'h1234_0000_0000_0000, 2'b10, 0, 1);
        step(0, 1, 64'h0000_0001_0000_0100, 2'b10, 0, 0);
        // R8: vector-length bit set
        step(0, 1, 64'h0000_0000_0000_0010, 2'b11, 1, 1);
        step(0, 1, 64'h0, 2'b10, 1, 0);
        // R9: real and virtual-8086 modes
        step(0, 1, 64'h0000_0000_0000_0004, 2'b00, 0, 1);
        step(0, 1, 64'h0, 2'b01, 0, 0);
        // R10: idle cycle
        step(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 0, 1);
        step(0, 1, 64'h0000_0000_0000_0008, 2'b10, 0, 0);
        // R11: reset while valid input is present
        step(1, 1, 64'h0000_0000_0000_0008, 2'b11, 0, 1);
        step(0, 1, 64'h0000_0000_0000_0008, 2'b00, 0, 1);
        for (int k = 0; k < 3000; k++) begin
            logic [63:0] s;
            int sel;
            s = {$urandom, $urandom};
            sel = $urandom % 6;
            if (sel == 0) s = '0;
            else if (sel == 1) s = s << ($urandom % 64);
            step(($urandom % 97) == 0, ($urandom % 5) != 0, s, 2'($urandom),
                 ($urandom % 8) == 0, 1'($urandom));
        end
        step(0, 0, '0, 2'b00, 0, 0);
        @(negedge clk);
        compare();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule